// File: doc/BRIEF.md
# Configurable PN Sequence Bit Generator

This block emits a serial stream containing a programmed number of bits, at most one bit per clock and only on clocks where the enable input is high. In each run it uses one of three sources. The first is a 15-stage maximal-length shift register built on the polynomial 1 + x^14 + x^15, in Fibonacci form with the feedback XOR outside the register. The second is the same register in Galois form, with the XOR placed inside the register at the tap stage. The third repeats a user-supplied base pattern of programmable length.

A one-cycle start pulse captures the mode, the seed, the run length and the pattern. It also clears the bit counter. Each output bit comes with a one-cycle valid strobe. When the requested number of bits has been produced, a done flag rises and stays high until the next start.

The control path is a three-state machine:
- IDLE is the state after reset.
- RUN is the state in which bits are produced.
- DONE holds at the end of a run.

The transitions are:
- LAUNCH: start, with a non-zero length, moves from any state to RUN.
- SKIP: start, with a zero bit count or a zero pattern length, moves from any state straight to DONE.
- FINISH: in RUN, the enabled clock that produces the last bit moves to DONE.
- Every other case holds the current state.

Top module: `pn_bitgen`

## Requirements
- R1: After reset, `done`, `bit_valid` and `bit_out` are all 0. No bit is produced until a start pulse arrives.
- R2: A clock edge with `start` high does the following:
  - It loads the register with `seed` when `seed_use` is 1. Otherwise it loads the default seed 169 (binary 000000010101001).
  - It clears the bit counter.
  - It gives `bit_valid` = 0 on that edge. The first bit appears on the next enabled clock.
- R3: With `mode` = 2'b00 (Fibonacci), each output bit is the XOR of register stages 14 and 13. The register then shifts toward stage 14, and the output bit enters stage 0. With the default seed, the first eight bits are 0,0,0,0,0,0,1,1.
- R4: With `mode` = 2'b01 (Galois), the output bit is stage 14. The next register value is {s[13] ^ out, s[12:0], out}. With the default seed, the first sixteen bits are 0,0,0,0,0,0,0,1,1,0,0,1,1,1,0,0.
- R5: With `mode[1]` = 1 (pattern), the bits emitted are `pattern[0]`, `pattern[1]`, and so on up to `pattern[L-1]`. The sequence then wraps back to `pattern[0]`. L is `pat_len`, and any value above 64 is treated as 64.
- R6: A run emits exactly `bit_count` bits when `count_use` is 1, and 128 bits otherwise. `done` rises on the edge that presents the last bit. After that, `done` stays high and `bit_valid` stays low until the next start.
- R7: A start with a bit count of 0, or with pattern mode and `pat_len` = 0, emits no bit. It sets `done` on the start edge itself.
- R8: An all-zero seed in either shift-register mode produces 0 on every bit.
- R9: `bit_valid` is high exactly on the RUN-state clocks where `en` is high. A clock with `en` low produces nothing and leaves the sequence position unchanged.
- R10: A start during a run abandons that run and begins a new one from the newly loaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new run and capture the settings |
| en | input | 1 | Produce one bit on this clock |
| mode | input | 2 | 00 Fibonacci, 01 Galois, 1x pattern |
| seed_use | input | 1 | Use `seed` rather than the default seed |
| seed | input | 15 | Initial register value |
| count_use | input | 1 | Use `bit_count` rather than the default count of 128 |
| bit_count | input | 16 | Number of bits in the run |
| pattern | input | 64 | Base pattern, emitted LSB first |
| pat_len | input | 7 | Number of pattern bits that repeat |
| bit_out | output | 1 | Generated bit |
| bit_valid | output | 1 | Strobe marking `bit_out` as valid |
| done | output | 1 | High once the run has completed |

## Verification
The bench builds the block with its default parameters: a 15-stage register, a 64-bit pattern field and a 16-bit counter. With these values the full default 128-bit run fits in a short test. So do a 64-bit pattern wrapping at its widest length and a gapped enable. The published Fibonacci and Galois prefixes from the default seed serve as fixed anchors. All other runs are compared bit by bit against a model written from the register update formulas.

// File: rtl/pn_pkg.sv
package pn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;
endpackage

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core #(
    parameter int LFSR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    input  logic              galois,
    output logic              cur_bit
);
    logic [LFSR_W-1:0] sreg;
    logic [LFSR_W-1:0] sreg_nxt;
    logic              fb;

    always_comb begin
        fb       = galois ? sreg[LFSR_W-1] : (sreg[LFSR_W-1] ^ sreg[LFSR_W-2]);
        sreg_nxt = {sreg[LFSR_W-2:0], fb};
        if (galois) begin
            sreg_nxt[LFSR_W-1] = sreg[LFSR_W-2] ^ fb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= seed;
        end else if (step) begin
            sreg <= sreg_nxt;
        end
    end

    assign cur_bit = fb;
endmodule

// File: rtl/pn_pattern_core.sv
module pn_pattern_core #(
    parameter int PAT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       step,
    input  logic [PAT_W-1:0]           pattern,
    input  logic [$clog2(PAT_W+1)-1:0] len,
    output logic                       cur_bit
);
    localparam int LEN_W = $clog2(PAT_W + 1);
    localparam int IDX_W = $clog2(PAT_W);

    logic [PAT_W-1:0] pat_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx;
    logic             wrap;

    assign wrap = (LEN_W'(idx) + LEN_W'(1)) >= len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
            len_q <= '0;
            idx   <= '0;
        end else if (load) begin
            pat_q <= pattern;
            len_q <= len;
            idx   <= '0;
        end else if (step) begin
            idx <= wrap ? '0 : idx + IDX_W'(1);
        end
    end

    assign cur_bit = pat_q[idx];
endmodule

// File: rtl/pn_run_ctrl.sv
module pn_run_ctrl
    import pn_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    input  logic             empty,
    output logic             step,
    output logic             done
);
    run_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tgt_q;
    logic             cnt_last;

    assign cnt_last = (cnt + CNT_W'(1)) == tgt_q;

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: st_nxt = ST_IDLE;
            ST_RUN:  if (en && cnt_last) st_nxt = ST_DONE;   // FINISH
            ST_DONE: st_nxt = ST_DONE;
            default: st_nxt = ST_IDLE;
        endcase
        if (start) begin
            st_nxt = (target == '0 || empty) ? ST_DONE : ST_RUN; // SKIP / LAUNCH
        end
    end

    // state register and run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            tgt_q <= '0;
        end else begin
            st <= st_nxt;
            if (start) begin
                cnt   <= '0;
                tgt_q <= target;
            end else if (step) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        step = (st == ST_RUN) && en && !start;
        done = (st == ST_DONE);
    end
endmodule

// File: rtl/pn_bitgen.sv
module pn_bitgen #(
    parameter int LFSR_W        = 15,
    parameter int PAT_W         = 64,
    parameter int CNT_W         = 16,
    parameter int DEFAULT_SEED  = 169,
    parameter int DEFAULT_COUNT = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       en,
    input  logic [1:0]                 mode,
    input  logic                       seed_use,
    input  logic [LFSR_W-1:0]          seed,
    input  logic                       count_use,
    input  logic [CNT_W-1:0]           bit_count,
    input  logic [PAT_W-1:0]           pattern,
    input  logic [$clog2(PAT_W+1)-1:0] pat_len,
    output logic                       bit_out,
    output logic                       bit_valid,
    output logic                       done
);
    localparam int LEN_W = $clog2(PAT_W + 1);

    logic [1:0]        mode_q;
    logic [LFSR_W-1:0] seed_sel;
    logic [CNT_W-1:0]  target;
    logic [LEN_W-1:0]  len_eff;
    logic              empty;
    logic              step;
    logic              lfsr_bit;
    logic              pat_bit;

    assign seed_sel = seed_use ? seed : LFSR_W'(DEFAULT_SEED);
    assign target   = count_use ? bit_count : CNT_W'(DEFAULT_COUNT);
    assign len_eff  = (pat_len > LEN_W'(PAT_W)) ? LEN_W'(PAT_W) : pat_len;
    assign empty    = mode[1] && (pat_len == '0);

    pn_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .en     (en),
        .target (target),
        .empty  (empty),
        .step   (step),
        .done   (done)
    );

    pn_lfsr_core #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .seed    (seed_sel),
        .step    (step && !mode_q[1]),
        .galois  (mode_q[0]),
        .cur_bit (lfsr_bit)
    );

    pn_pattern_core #(.PAT_W(PAT_W)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .step    (step && mode_q[1]),
        .pattern (pattern),
        .len     (len_eff),
        .cur_bit (pat_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 2'b00;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            if (start) begin
                mode_q <= mode;
            end
            bit_valid <= step;
            if (step) begin
                bit_out <= mode_q[1] ? pat_bit : lfsr_bit;
            end
        end
    end
endmodule

// File: rtl/pn_bitgen_chk.sv
module pn_bitgen_chk #(
    parameter int LFSR_W = 15,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              en,
    input logic [1:0]        mode,
    input logic              seed_use,
    input logic [LFSR_W-1:0] seed,
    input logic [LEN_W-1:0]  pat_len,
    input logic              bit_out,
    input logic              bit_valid,
    input logic              done
);
    logic zero_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_run <= 1'b0;
        end else if (start) begin
            zero_run <= !mode[1] && seed_use && (seed == '0);
        end
    end

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !bit_valid); // R2

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !bit_valid)); // R6

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode[1] && pat_len == '0) |=> (done && !bit_valid)); // R7

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && zero_run) |-> !bit_out); // R8

    AST_VALID_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(en)); // R9
endmodule

bind pn_bitgen pn_bitgen_chk #(.LFSR_W(LFSR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .en        (en),
    .mode      (mode),
    .seed_use  (seed_use),
    .seed      (seed),
    .pat_len   (pat_len),
    .bit_out   (bit_out),
    .bit_valid (bit_valid),
    .done      (done)
);

// File: tb/sim_pn_bitgen.sv
module sim_pn_bitgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        seed_use = 1'b0;
    logic [14:0] seed = '0;
    logic        count_use = 1'b0;
    logic [15:0] bit_count = '0;
    logic [63:0] pattern = '0;
    logic [6:0]  pat_len = '0;
    logic        bit_out, bit_valid, done;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [14:0] ms;
    logic [1:0]  mmode;
    logic [63:0] mpat;
    int          mlen;
    int          midx;
    bit          cap [0:255];

    always #2 clk = ~clk; // 250 MHz

    pn_bitgen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .en(en), .mode(mode),
        .seed_use(seed_use), .seed(seed), .count_use(count_use),
        .bit_count(bit_count), .pattern(pattern), .pat_len(pat_len),
        .bit_out(bit_out), .bit_valid(bit_valid), .done(done)
    );

    task automatic check_eq(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic bit model_step();
        bit b;
        if (mmode[1]) begin
            b = mpat[midx];
            midx = (midx + 1 >= mlen) ? 0 : midx + 1;
        end else if (mmode[0]) begin
            b = ms[14];
            ms = {ms[13] ^ b, ms[12:0], b};
        end else begin
            b = ms[14] ^ ms[13];
            ms = {ms[13:0], b};
        end
        return b;
    endfunction

    // issue a start pulse (called at a negedge)
    task automatic kick(input logic [1:0] md, input bit su, input logic [14:0] sd,
                        input bit cu, input logic [15:0] cnt,
                        input logic [63:0] pat, input logic [6:0] len);
        mode = md; seed_use = su; seed = sd; count_use = cu; bit_count = cnt;
        pattern = pat; pat_len = len; start = 1'b1; en = 1'b1;
        ms = su ? sd : 15'd169;
        mmode = md; mpat = pat; mlen = (len > 64) ? 64 : int'(len); midx = 0;
        @(negedge clk);
        start = 1'b0; en = 1'b0;
        check_eq("R2", "valid on start edge", bit_valid, 0);
    endtask

    // take n_take bits of an n_total run, comparing each with the model
    task automatic collect(input int n_total, input int n_take, input bit gaps, input string rq);
        int got = 0;
        int cyc = 0;
        while (got < n_take && cyc < n_take * 3 + 10) begin
            en = gaps ? (cyc % 3 != 1) : 1'b1;
            @(negedge clk);
            check_eq("R9", "valid follows en", bit_valid, en);
            if (bit_valid) begin
                bit exp_b;
                exp_b = model_step();
                if (got < 256) cap[got] = bit_out;
                check_eq(rq, $sformatf("bit %0d", got), bit_out, exp_b);
                got++;
            end
            check_eq("R6", "done vs bits produced", done, (got == n_total) ? 1 : 0);
            cyc++;
        end
        check_eq("R6", "bits produced", got, n_take);
        en = 1'b0;
        if (n_take == n_total) begin
            for (int i = 0; i < 4; i++) begin
                en = 1'b1;
                @(negedge clk);
                check_eq("R6", "no bit after done", bit_valid, 0);
                check_eq("R6", "done holds", done, 1);
            end
            en = 1'b0;
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "done after reset", done, 0);
        check_eq("R1", "valid after reset", bit_valid, 0);
        check_eq("R1", "bit after reset", bit_out, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "no bit before start", bit_valid, 0);
        en = 1'b0;
    endtask

    task automatic t_fib_default();
        bit [0:7] f8 = 8'b00000011;
        kick(2'b00, 1'b0, 15'h7fff, 1'b1, 16'd8, '0, '0);
        collect(8, 8, 1'b0, "R3");
        for (int i = 0; i < 8; i++) check_eq("R3", $sformatf("fixed prefix %0d", i), cap[i], f8[i]);
    endtask

    task automatic t_gal_default();
        bit [0:15] g16 = 16'b0000000110011100;
        kick(2'b01, 1'b0, '0, 1'b1, 16'd16, '0, '0);
        collect(16, 16, 1'b0, "R4");
        for (int i = 0; i < 16; i++) check_eq("R4", $sformatf("fixed prefix %0d", i), cap[i], g16[i]);
        // default count of 128
        kick(2'b01, 1'b1, 15'h5a3c, 1'b0, 16'd3, '0, '0);
        collect(128, 128, 1'b0, "R4");
    endtask

    task automatic t_pattern();
        kick(2'b10, 1'b0, '0, 1'b1, 16'd13, 64'hFFFF_FFFF_FFFF_FF16, 7'd5);
        collect(13, 13, 1'b0, "R5");
        kick(2'b11, 1'b0, '0, 1'b1, 16'd70, 64'h0123_4567_89AB_CDEF, 7'd64);
        collect(70, 70, 1'b0, "R5");
        kick(2'b10, 1'b0, '0, 1'b1, 16'd66, 64'h8000_0000_0000_0001, 7'd100);
        collect(66, 66, 1'b0, "R5");
    endtask

    task automatic t_empty();
        kick(2'b10, 1'b0, '0, 1'b1, 16'd10, 64'hFFFF, 7'd0);
        check_eq("R7", "done at once, pattern length 0", done, 1);
        collect(0, 0, 1'b0, "R7");
        kick(2'b00, 1'b1, 15'h1234, 1'b1, 16'd0, '0, '0);
        check_eq("R7", "done at once, count 0", done, 1);
        collect(0, 0, 1'b0, "R7");
    endtask

    task automatic t_zero_seed();
        kick(2'b01, 1'b1, 15'h0000, 1'b1, 16'd20, '0, '0);
        collect(20, 20, 1'b0, "R8");
        kick(2'b00, 1'b1, 15'h0000, 1'b1, 16'd20, '0, '0);
        collect(20, 20, 1'b0, "R8");
    endtask

    task automatic t_gaps();
        kick(2'b00, 1'b1, 15'h1234, 1'b1, 16'd30, '0, '0);
        collect(30, 30, 1'b1, "R9");
    endtask

    task automatic t_restart();
        kick(2'b00, 1'b1, 15'h2d71, 1'b1, 16'd40, '0, '0);
        collect(40, 5, 1'b0, "R10");
        kick(2'b01, 1'b1, 15'h0f0f, 1'b1, 16'd12, '0, '0);
        check_eq("R10", "done low after restart", done, 0);
        collect(12, 12, 1'b0, "R10");
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fib_default();
        t_gal_default();
        t_pattern();
        t_empty();
        t_zero_seed();
        t_gaps();
        t_restart();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule